// File: doc/BRIEF.md
# Configurable Interrupt Source Controller

This block gathers sixteen interrupt conditions into one interrupt request line. The conditions are frame-valid start and end, six command-line inputs, and four fill-level flags from each of a transmit FIFO and a receive FIFO. The block places each condition at a fixed bit position. Each bit can then be set up on its own in three ways: it can be enabled, it can be edge-triggered or level-sensitive, and it can be active high or active low.

The pending bits are kept apart from the enable mask. A source that is masked still records its events in the pending register, so software can poll that register. Writing a 1 to a pending bit clears it. The interrupt request is the OR of every pending bit whose enable is set.

A simple register port handles access. A write port has an address, a data word and a strobe. A read port has its own address and returns data combinationally.

Top module: `irq_source_ctrl`

## Requirements
- R1: Source bit positions are as follows. Frame-valid start is bit 0 and frame-valid end is bit 1. The transmit flags {empty, almost-empty, almost-full, full} = tx_flags_i[0..3] map to bits 8..11. The receive flags in the same order = rx_flags_i[0..3] map to bits 12..15.
- R2: Command line n, for n from 1 to 6, is driven on cmd_line_i[n-1] and maps to source bit n+1. Bits 2..7 therefore hold lines 1..6.
- R3: Register addresses are 0 = enable mask, 1 = pending status, 2 = mode select (1 = edge, 0 = level) and 3 = polarity (1 = active high, 0 = active low). After reset, enable, pending and mode are all zero and polarity is all ones. rd_data shows the register selected by rd_addr in the same cycle.
- R4: In edge mode, a pending bit is set by the clock edge that first samples its source active after that source was sampled inactive. The bit then stays set after the source goes inactive. At reset the previous sample counts as inactive.
- R5: Writing address 1 clears, at the next clock edge, each edge-mode pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged, and a write never sets a pending bit.
- R6: In level mode, a pending bit equals the active state sampled at the previous clock edge. A clear write has no effect on it while that source stays active.
- R7: A source is active when its input equals its polarity bit, so polarity 0 makes a low input active.
- R8: If a clear and a new edge reach the same bit in the same cycle, the bit is set after the clock edge.
- R9: irq_o is high exactly when some pending bit has its enable bit set. Pending bits keep updating while their enable bit is 0.
- R10: A write of zero to the enable register drives irq_o low from the next clock edge, whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-valid start condition |
| frame_end_i | input | 1 | Frame-valid end condition |
| tx_flags_i | input | 4 | Transmit FIFO empty, almost-empty, almost-full, full |
| rx_flags_i | input | 4 | Receive FIFO empty, almost-empty, almost-full, full |
| cmd_line_i | input | 6 | Command lines 1..6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Selected register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
Suppose the stored previous-sample state is wrong. The result is a pending bit that sets with no transition, or a missed transition. Either one shows on the pending read and on irq_o one clock edge after the input change. A corrupted mode or polarity bit makes a level source hold through a clear, or fire on the wrong input value, within a single cycle. The bench therefore compares pending, irq_o and a register readback after every cycle against a cycle-accurate model. This catches any divergence on the cycle it happens.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC       = 16;
    localparam int FLAG_W     = 4;
    localparam int NCMD       = 6;
    localparam int ADDR_W     = 2;
    localparam int BIT_FSTART = 0;
    localparam int BIT_FEND   = 1;
    localparam int TX_BASE    = 8;
    localparam int RX_BASE    = TX_BASE + FLAG_W;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 2'd0,
        REG_PENDING  = 2'd1,
        REG_MODE     = 2'd2,
        REG_POLARITY = 2'd3
    } reg_sel_e;

    typedef struct packed {
        src_vec_t enable;
        src_vec_t edge_mode;
        src_vec_t polarity;
    } irq_cfg_t;

    function automatic logic cmd_line_ok(int line);
        return (line >= 1) && (line <= NCMD);
    endfunction

    function automatic int cmd_line_pos(int line);
        return line + 1;
    endfunction
endpackage

// File: rtl/irqc_src_map.sv
module irqc_src_map
    import irqc_pkg::*;
(
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic [FLAG_W-1:0] tx_flags_i,
    input  logic [FLAG_W-1:0] rx_flags_i,
    input  logic [NCMD-1:0]   cmd_line_i,
    output src_vec_t          src_o
);
    always_comb begin
        src_o = '0;
        src_o[BIT_FSTART] = frame_start_i;
        src_o[BIT_FEND]   = frame_end_i;
        for (int ln = 1; ln <= NCMD; ln++) begin
            if (cmd_line_ok(ln))
                src_o[cmd_line_pos(ln)] = cmd_line_i[ln-1];
        end
        for (int k = 0; k < FLAG_W; k++) begin
            src_o[TX_BASE+k] = tx_flags_i[k];
            src_o[RX_BASE+k] = rx_flags_i[k];
        end
    end
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_i,
    input  src_vec_t edge_mode,
    input  src_vec_t polarity,
    input  src_vec_t clr_mask,
    output src_vec_t pend_o
);
    src_vec_t active, prev_q, rise, pend_q;

    // active when input matches polarity
    assign active = ~(src_i ^ polarity);
    assign rise   = active & ~prev_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= active[i];
                if (edge_mode[i])
                    pend_q[i] <= rise[i] | (pend_q[i] & ~clr_mask[i]);
                else
                    pend_q[i] <= active[i];
            end
        end
    end

    assign pend_o = pend_q;

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q & edge_mode & ~clr_mask) & ~pend_q) == '0));

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_q ^ $past(active)) & ~$past(edge_mode)) == '0));

    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rise & edge_mode) & ~pend_q) == '0));

    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(active)) == '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  src_vec_t          wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  src_vec_t          pend_i,
    output irq_cfg_t          cfg_o,
    output src_vec_t          clr_o,
    output src_vec_t          rd_data,
    output logic              irq_o
);
    irq_cfg_t cfg_q;
    reg_sel_e wsel, rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.enable    <= '0;
            cfg_q.edge_mode <= '0;
            cfg_q.polarity  <= '1;
        end else if (wr_en) begin
            case (wsel)
                REG_ENABLE:   cfg_q.enable    <= wr_data;
                REG_MODE:     cfg_q.edge_mode <= wr_data;
                REG_POLARITY: cfg_q.polarity  <= wr_data;
                default:      ;
            endcase
        end
    end

    assign clr_o = (wr_en && wsel == REG_PENDING) ? wr_data : '0;

    always_comb begin
        case (rsel)
            REG_ENABLE:   rd_data = cfg_q.enable;
            REG_PENDING:  rd_data = pend_i;
            REG_MODE:     rd_data = cfg_q.edge_mode;
            default:      rd_data = cfg_q.polarity;
        endcase
    end

    assign irq_o = |(pend_i & cfg_q.enable);
    assign cfg_o = cfg_q;

    assert_mask_off_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == REG_ENABLE && wr_data == '0) |=> !irq_o);

    assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_i != '0));
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic [FLAG_W-1:0] tx_flags_i,
    input  logic [FLAG_W-1:0] rx_flags_i,
    input  logic [NCMD-1:0]   cmd_line_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NSRC-1:0]   rd_data,
    output logic              irq_o
);
    src_vec_t src, pend, clr;
    irq_cfg_t cfg;

    irqc_src_map u_map (
        .frame_start_i(frame_start_i),
        .frame_end_i  (frame_end_i),
        .tx_flags_i   (tx_flags_i),
        .rx_flags_i   (rx_flags_i),
        .cmd_line_i   (cmd_line_i),
        .src_o        (src)
    );

    irqc_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src),
        .edge_mode(cfg.edge_mode),
        .polarity (cfg.polarity),
        .clr_mask (clr),
        .pend_o   (pend)
    );

    irqc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .pend_i (pend),
        .cfg_o  (cfg),
        .clr_o  (clr),
        .rd_data(rd_data),
        .irq_o  (irq_o)
    );

    assert_reset_state_R3: assert property (@(posedge clk)
        rst |=> (pend == '0 && !irq_o));
endmodule

// File: tb/test_irq_source_ctrl.sv
`timescale 1ns/1ps
module test_irq_source_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        fs, fe;
    logic [3:0]  txf, rxf;
    logic [5:0]  cmd;
    logic        we;
    logic [1:0]  wa, ra;
    logic [15:0] wd;
    logic [15:0] rd;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_en, m_pend, m_mode, m_pol, m_prev;

    always #2.5 clk = ~clk;

    irq_source_ctrl i_irq_source_ctrl (
        .clk(clk), .rst(rst), .frame_start_i(fs), .frame_end_i(fe),
        .tx_flags_i(txf), .rx_flags_i(rxf), .cmd_line_i(cmd),
        .wr_en(we), .wr_addr(wa), .wr_data(wd), .rd_addr(ra),
        .rd_data(rd), .irq_o(irq)
    );

    function automatic logic [15:0] pack_src(logic a, logic b, logic [3:0] t,
                                             logic [3:0] r, logic [5:0] c);
        return {r, t, c, b, a};
    endfunction

    function automatic logic [15:0] reg_view(logic [1:0] a);
        case (a)
            2'd0: return m_en;
            2'd1: return m_pend;
            2'd2: return m_mode;
            default: return m_pol;
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(string tag);
        logic [15:0] act, clr, nxt;
        act = ~(pack_src(fs, fe, txf, rxf, cmd) ^ m_pol);
        clr = (we && wa == 2'd1) ? wd : 16'h0;
        nxt = (~m_mode & act) | (m_mode & ((act & ~m_prev) | (m_pend & ~clr)));
        @(posedge clk);
        m_prev = act;
        m_pend = nxt;
        if (we) begin
            if (wa == 2'd0) m_en = wd;
            if (wa == 2'd2) m_mode = wd;
            if (wa == 2'd3) m_pol = wd;
        end
        #1;
        chk({tag, " irq"}, {15'h0, irq}, {15'h0, |(m_pend & m_en)});
        chk({tag, " rd"}, rd, reg_view(ra));
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d, string tag);
        we = 1'b1; wa = a; wd = d;
        cycle(tag);
    endtask

    task automatic idle_src();
        fs = 0; fe = 0; txf = 0; rxf = 0; cmd = 0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5521));
        rst = 1; idle_src(); we = 0; wa = 0; wd = 0; ra = 2'd1;
        m_en = 0; m_pend = 0; m_mode = 0; m_pol = 16'hFFFF; m_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R3 reset state
        ra = 2'd3; #0.1; chk("R3 polarity reset", rd, 16'hFFFF);
        ra = 2'd1; #0.1; chk("R3 pending reset", rd, 16'h0);
        chk("R3 irq reset", {15'h0, irq}, 16'h0);

        // R1 positions in level mode
        txf = 4'b0001; cycle("R1");
        chk("R1 tx empty bit8", rd, 16'h0100);
        idle_src(); rxf = 4'b1000; fe = 1; cycle("R1");
        chk("R1 rx full bit15 and frame end bit1", rd, 16'h8002);
        // R2 command line 1 -> bit2, line 6 -> bit7
        idle_src(); cmd = 6'b100001; cycle("R2");
        chk("R2 cmd lines 1,6", rd, 16'h0084);
        idle_src(); cycle("R6");
        chk("R6 level drops", rd, 16'h0);

        // R4 edge mode hold
        wr(2'd2, 16'hFFFF, "R4");
        wr(2'd0, 16'h0001, "R9");
        fs = 1; cycle("R4");
        chk("R4 edge set", rd, 16'h0001);
        chk("R9 irq on enabled", {15'h0, irq}, 16'h1);
        fs = 0; cycle("R4");
        chk("R4 held after drop", rd, 16'h0001);
        // R5 clear
        wr(2'd1, 16'h0001, "R5");
        chk("R5 cleared", rd, 16'h0);
        // R8 clear with new edge
        fs = 1; wr(2'd1, 16'h0001, "R8");
        chk("R8 edge wins", rd, 16'h0001);
        fs = 0;
        // R9 disabled source still pends
        fe = 1; cycle("R9");
        chk("R9 masked pending", rd, 16'h0003);
        // R10 zero enable
        wr(2'd0, 16'h0000, "R10");
        chk("R10 irq low", {15'h0, irq}, 16'h0);
        wr(2'd1, 16'hFFFF, "R5"); idle_src();

        // R6 level clear ignored while active; R7 polarity low
        wr(2'd2, 16'h0000, "R6");
        wr(2'd3, 16'hFFFE, "R7");
        chk("R7 low input active", rd, 16'h0000);
        cycle("R7");
        chk("R7 bit0 active low", rd, 16'h0001);
        wr(2'd1, 16'h0001, "R6");
        chk("R6 clear ignored", rd, 16'h0001);
        fs = 1; cycle("R7");
        chk("R7 high input inactive", rd, 16'h0000);
        wr(2'd3, 16'hFFFF, "R7");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            {fs, fe} = 2'($urandom);
            txf = 4'($urandom); rxf = 4'($urandom); cmd = 6'($urandom);
            ra = 2'($urandom);
            we = ($urandom % 4) == 0;
            wa = 2'($urandom); wd = 16'($urandom);
            cycle("R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule